// File: doc/BRIEF.md
# SPI Bus Monitor

This block watches the four lines of an SPI bus without ever driving them: serial clock, chip select, controller-to-peripheral data (MOSI) and peripheral-to-controller data (MISO). All four lines are brought into the fast system clock domain through two-flop synchronisers. SCLK edges are then found by comparing each synchronised level with a copy delayed by one cycle. The system clock must run at least four times faster than SCLK. Data bits are taken on the edge that the selected clock polarity and phase call for. Each channel builds its own word, and each completed pair of words is presented with a one-cycle strobe.

Every change on chip select is reported with the level before and the level after. Such a change also throws away any word still being assembled, so a word never spans two selections. Software-free configuration inputs select clock polarity, clock phase, chip-select polarity, bit order, word length (4 to 128 bits), the use of chip select, and which data channels are in use. Without chip select, words are framed only by counting bits.

The result outputs are a pure stream with a valid strobe and no ready. There is no back-pressure: a consumer must take every strobed word and event in the cycle it is shown. The data stays on the outputs until the next strobe.

Top module: `spi_bus_monitor`

## Requirements
- R1: While reset is high and in the first cycle after it, word_valid and cs_evt_valid are 0, and mosi_word, miso_word, mosi_ok and miso_ok are all 0.
- R2: The sampling edge follows the clock mode. With cfg_cpol equal to cfg_cpha (modes 0 and 3), a bit is taken on a rising SCLK edge. With them different (modes 1 and 2), it is taken on a falling edge. A controller that sets up data before the leading edge and holds it past the trailing edge gives back its sent word in all four modes.
- R3: A sampling edge is ignored while chip select is in use and not asserted. Chip select is asserted when its level is 0 with cfg_cs_active_high=0, or 1 with cfg_cs_active_high=1.
- R4: While chip select is in use, every level change of it has three effects. It clears the bit count and both partial words. It drives cs_evt_valid for one cycle with cs_evt_old_known=1, cs_evt_old the previous level and cs_evt_new the new level. It discards any SCLK edge seen in that same cycle.
- R5: When chip select is in use, cs_evt_valid pulses once on the third clock edge after reset falls. That event has cs_evt_old_known=0, cs_evt_old=0, and cs_evt_new equal to the chip-select level present at the first edge after reset.
- R6: With cfg_lsb_first=0, received bit k of a word is placed at position L-1-k, where L is the effective word length. With cfg_lsb_first=1 it is placed at position k. All output bits at L and above are 0.
- R7: The effective word length L is cfg_word_len clamped to the range 4..128. word_valid pulses for one cycle when the L-th accepted bit arrives, after which counting restarts at bit 0. An SCLK edge applied at the pins before system clock edge n gives word_valid after edge n+2.
- R8: With a channel's enable input at 1, its ok output is 1 in each word. With the enable at 0, its ok output is 0 and its word output is 0.
- R9: With cfg_cs_en=0, chip-select changes produce no events and are not framing points. Every sampling edge is accepted, and words are framed by bit count only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Observed serial clock |
| spi_cs | input | 1 | Observed chip select |
| spi_mosi | input | 1 | Observed controller-to-peripheral data |
| spi_miso | input | 1 | Observed peripheral-to-controller data |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| cfg_cs_active_high | input | 1 | 1: chip select asserted when high |
| cfg_cs_en | input | 1 | 1: chip select is used for gating and framing |
| cfg_lsb_first | input | 1 | 1: first received bit is the least significant |
| cfg_word_len | input | 8 | Word length in bits, clamped to 4..128 |
| cfg_mosi_en | input | 1 | MOSI channel in use |
| cfg_miso_en | input | 1 | MISO channel in use |
| word_valid | output | 1 | One-cycle strobe for a completed word pair |
| mosi_word | output | 128 | Assembled MOSI word |
| mosi_ok | output | 1 | MOSI word is meaningful |
| miso_word | output | 128 | Assembled MISO word |
| miso_ok | output | 1 | MISO word is meaningful |
| cs_evt_valid | output | 1 | One-cycle strobe for a chip-select event |
| cs_evt_old_known | output | 1 | 0 on the startup event |
| cs_evt_old | output | 1 | Chip-select level before the event |
| cs_evt_new | output | 1 | Chip-select level after the event |

## Verification
The hardest case to reach is a chip-select change and a sampling SCLK edge landing in the very same system cycle. In that case the clock edge must be dropped rather than counted into the new frame. The bench reaches it by driving both pins at one falling system-clock edge. A stray bit would show up as a shifted word in the following frame. Partial words cut off by a chip-select change, and the startup event before any edge detection is live, are also driven deliberately. A behavioural model predicts every output on every cycle.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

  localparam int SIG_SCLK = 0;
  localparam int SIG_CS   = 1;
  localparam int SIG_MOSI = 2;
  localparam int SIG_MISO = 3;
  localparam int SIG_N    = 4;
  localparam int EDGE_N   = 2;

  localparam int LANE_MOSI = 0;
  localparam int LANE_MISO = 1;
  localparam int LANE_N    = 2;

  typedef enum logic {
    SMP_RISE = 1'b0,
    SMP_FALL = 1'b1
  } smp_edge_e;

  function automatic smp_edge_e pick_edge(input logic cpol, input logic cpha);
    return (cpol == cpha) ? SMP_RISE : SMP_FALL;
  endfunction

endpackage

// File: rtl/spi_mon_front.sv
module spi_mon_front #(
  parameter int SIG_W       = 4,
  parameter int EDGE_W      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int WARM_W     = $clog2(SYNC_STAGES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIG_W-1:0]  pins,
  output logic [SIG_W-1:0]  cur,
  output logic [EDGE_W-1:0] prv,
  output logic              live,
  output logic              init_pulse
);

  logic [SIG_W-1:0]  stg [SYNC_STAGES];
  logic [EDGE_W-1:0] dly;
  logic [WARM_W-1:0] warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= pins;
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dly  <= '0;
      warm <= '0;
    end else begin
      dly <= stg[SYNC_STAGES-1][EDGE_W-1:0];
      if (warm != WARM_W'(SYNC_STAGES + 1)) warm <= warm + WARM_W'(1);
    end
  end

  assign cur        = stg[SYNC_STAGES-1];
  assign prv        = dly;
  assign live       = (warm == WARM_W'(SYNC_STAGES + 1));
  assign init_pulse = (warm == WARM_W'(SYNC_STAGES));

  p_live_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    live |=> live);
  p_init_once_r5: assert property (@(posedge clk) disable iff (rst)
    init_pulse |=> (!init_pulse && live));

endmodule

// File: rtl/spi_mon_lane.sv
module spi_mon_lane #(
  parameter int WORD_W = 128,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              take,
  input  logic              done,
  input  logic              clear,
  input  logic [IDX_W-1:0]  pos,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word,
  output logic              word_ok
);

  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] acc_next;

  always_comb begin
    acc_next = acc | (WORD_W'(bit_in) << pos);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      word    <= '0;
      word_ok <= 1'b0;
    end else if (clear) begin
      acc <= '0;
    end else if (done) begin
      acc     <= '0;
      word    <= en ? acc_next : '0;
      word_ok <= en;
    end else if (take) begin
      acc <= acc_next;
    end
  end

  p_dis_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !word_ok |-> (word == '0));
  p_acc_clear_r4: assert property (@(posedge clk) disable iff (rst)
    clear |=> (acc == '0));

endmodule

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor #(
  parameter int  MAX_WORD = 128,
  parameter int  MIN_WORD = 4,
  parameter int  SYNC_STAGES = 2,
  localparam int LEN_W = $clog2(MAX_WORD + 1),
  localparam int IDX_W = $clog2(MAX_WORD)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                spi_sclk,
  input  logic                spi_cs,
  input  logic                spi_mosi,
  input  logic                spi_miso,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic                cfg_cs_active_high,
  input  logic                cfg_cs_en,
  input  logic                cfg_lsb_first,
  input  logic [LEN_W-1:0]    cfg_word_len,
  input  logic                cfg_mosi_en,
  input  logic                cfg_miso_en,
  output logic                word_valid,
  output logic [MAX_WORD-1:0] mosi_word,
  output logic                mosi_ok,
  output logic [MAX_WORD-1:0] miso_word,
  output logic                miso_ok,
  output logic                cs_evt_valid,
  output logic                cs_evt_old_known,
  output logic                cs_evt_old,
  output logic                cs_evt_new
);
  import spi_mon_pkg::*;

  logic [SIG_N-1:0]  pins;
  logic [SIG_N-1:0]  cur;
  logic [EDGE_N-1:0] prv;
  logic              live;
  logic              init_pulse;

  assign pins[SIG_SCLK] = spi_sclk;
  assign pins[SIG_CS]   = spi_cs;
  assign pins[SIG_MOSI] = spi_mosi;
  assign pins[SIG_MISO] = spi_miso;

  spi_mon_front #(
    .SIG_W(SIG_N), .EDGE_W(EDGE_N), .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk(clk), .rst(rst), .pins(pins), .cur(cur), .prv(prv),
    .live(live), .init_pulse(init_pulse)
  );

  // Decode of edges and framing
  logic       sclk_rise, sclk_fall, smp_hit;
  logic       cs_chg, cs_act;
  logic       take, done;
  smp_edge_e  smp_sel;
  logic [LEN_W-1:0] len_eff;
  logic [LEN_W-1:0] last_idx;
  logic [IDX_W-1:0] bit_cnt;
  logic [IDX_W-1:0] bit_pos;

  always_comb begin
    if (cfg_word_len < LEN_W'(MIN_WORD))      len_eff = LEN_W'(MIN_WORD);
    else if (cfg_word_len > LEN_W'(MAX_WORD)) len_eff = LEN_W'(MAX_WORD);
    else                                      len_eff = cfg_word_len;
    last_idx = len_eff - LEN_W'(1);
  end

  always_comb begin
    sclk_rise = cur[SIG_SCLK] & ~prv[SIG_SCLK];
    sclk_fall = ~cur[SIG_SCLK] & prv[SIG_SCLK];
    smp_sel   = pick_edge(cfg_cpol, cfg_cpha);
    smp_hit   = (smp_sel == SMP_RISE) ? sclk_rise : sclk_fall;
    cs_chg    = live & cfg_cs_en & (cur[SIG_CS] ^ prv[SIG_CS]);
    cs_act    = !cfg_cs_en ||
                (cfg_cs_active_high ? cur[SIG_CS] : !cur[SIG_CS]);
    take      = live & !cs_chg & smp_hit & cs_act;
    done      = take & (LEN_W'(bit_cnt) >= last_idx);
    bit_pos   = cfg_lsb_first ? bit_cnt : (IDX_W'(last_idx) - bit_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
    end else if (cs_chg || done) begin
      bit_cnt <= '0;
    end else if (take) begin
      bit_cnt <= bit_cnt + IDX_W'(1);
    end
  end

  // Word lanes
  logic                lane_bit  [LANE_N];
  logic                lane_en   [LANE_N];
  logic [MAX_WORD-1:0] lane_word [LANE_N];
  logic                lane_ok   [LANE_N];

  assign lane_bit[LANE_MOSI] = cur[SIG_MOSI];
  assign lane_bit[LANE_MISO] = cur[SIG_MISO];
  assign lane_en[LANE_MOSI]  = cfg_mosi_en;
  assign lane_en[LANE_MISO]  = cfg_miso_en;

  for (genvar gi = 0; gi < LANE_N; gi++) begin : g_lane
    spi_mon_lane #(.WORD_W(MAX_WORD)) u_lane (
      .clk(clk), .rst(rst), .en(lane_en[gi]), .take(take), .done(done),
      .clear(cs_chg), .pos(bit_pos), .bit_in(lane_bit[gi]),
      .word(lane_word[gi]), .word_ok(lane_ok[gi])
    );
  end

  assign mosi_word = lane_word[LANE_MOSI];
  assign mosi_ok   = lane_ok[LANE_MOSI];
  assign miso_word = lane_word[LANE_MISO];
  assign miso_ok   = lane_ok[LANE_MISO];

  // Strobes and chip-select events
  always_ff @(posedge clk) begin
    if (rst) begin
      word_valid       <= 1'b0;
      cs_evt_valid     <= 1'b0;
      cs_evt_old_known <= 1'b0;
      cs_evt_old       <= 1'b0;
      cs_evt_new       <= 1'b0;
    end else begin
      word_valid <= done;
      if (cs_chg) begin
        cs_evt_valid     <= 1'b1;
        cs_evt_old_known <= 1'b1;
        cs_evt_old       <= prv[SIG_CS];
        cs_evt_new       <= cur[SIG_CS];
      end else if (init_pulse && cfg_cs_en) begin
        cs_evt_valid     <= 1'b1;
        cs_evt_old_known <= 1'b0;
        cs_evt_old       <= 1'b0;
        cs_evt_new       <= cur[SIG_CS];
      end else begin
        cs_evt_valid <= 1'b0;
      end
    end
  end

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);
  p_cs_clear_r4: assert property (@(posedge clk) disable iff (rst)
    cs_chg |=> (bit_cnt == '0 && !word_valid));
  p_evt_diff_r4: assert property (@(posedge clk) disable iff (rst)
    (cs_evt_valid && cs_evt_old_known) |-> (cs_evt_old != cs_evt_new));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (live && cfg_cs_en && !cs_chg && !cs_act) |=> $stable(bit_cnt));
  p_no_evt_r9: assert property (@(posedge clk) disable iff (rst)
    cs_evt_valid |-> $past(cfg_cs_en));

endmodule

// File: tb/tb_spi_bus_monitor.sv
module tb_spi_bus_monitor;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic spi_sclk = 1'b0, spi_cs = 1'b1, spi_mosi = 1'b0, spi_miso = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_cs_active_high = 1'b0;
  logic cfg_cs_en = 1'b1, cfg_lsb_first = 1'b0;
  logic [7:0] cfg_word_len = 8'd8;
  logic cfg_mosi_en = 1'b1, cfg_miso_en = 1'b1;

  logic         word_valid, mosi_ok, miso_ok;
  logic [127:0] mosi_word, miso_word;
  logic         cs_evt_valid, cs_evt_old_known, cs_evt_old, cs_evt_new;

  spi_bus_monitor dut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs(spi_cs),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_cs_active_high(cfg_cs_active_high),
    .cfg_cs_en(cfg_cs_en), .cfg_lsb_first(cfg_lsb_first),
    .cfg_word_len(cfg_word_len), .cfg_mosi_en(cfg_mosi_en),
    .cfg_miso_en(cfg_miso_en), .word_valid(word_valid),
    .mosi_word(mosi_word), .mosi_ok(mosi_ok), .miso_word(miso_word),
    .miso_ok(miso_ok), .cs_evt_valid(cs_evt_valid),
    .cs_evt_old_known(cs_evt_old_known), .cs_evt_old(cs_evt_old),
    .cs_evt_new(cs_evt_new)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done_flag = 0;

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // Behavioural reference model
  logic [3:0] hist[$];
  int k = 0;
  int m_cnt = 0;
  logic [127:0] m_mo = '0, m_mi = '0;
  logic e_wv = 0, e_mo_ok = 0, e_mi_ok = 0;
  logic [127:0] e_mo = '0, e_mi = '0;
  logic e_ev = 0, e_known = 0, e_old = 0, e_new = 0;

  always @(posedge clk) begin
    if (rst) begin
      k = 0; hist.delete(); m_cnt = 0; m_mo = '0; m_mi = '0;
      e_wv = 0; e_mo = '0; e_mi = '0; e_mo_ok = 0; e_mi_ok = 0;
      e_ev = 0; e_known = 0; e_old = 0; e_new = 0;
    end else begin
      k++;
      e_wv = 0;
      e_ev = 0;
      if (k == 3 && cfg_cs_en) begin
        e_ev = 1; e_known = 0; e_old = 0; e_new = hist[hist.size()-2][1];
      end
      if (k >= 4) begin
        logic [3:0] c, p;
        int len, pos;
        bit smp, asserted;
        c = hist[hist.size()-2];
        p = hist[hist.size()-3];
        len = (cfg_word_len < 4) ? 4 : ((cfg_word_len > 128) ? 128 : int'(cfg_word_len));
        smp = (cfg_cpol == cfg_cpha) ? (c[0] && !p[0]) : (!c[0] && p[0]);
        asserted = !cfg_cs_en || (cfg_cs_active_high ? c[1] : !c[1]);
        if (cfg_cs_en && (c[1] != p[1])) begin
          e_ev = 1; e_known = 1; e_old = p[1]; e_new = c[1];
          m_cnt = 0; m_mo = '0; m_mi = '0;
        end else if (smp && asserted) begin
          pos = cfg_lsb_first ? m_cnt : (len - 1 - m_cnt);
          m_mo[pos] = c[2];
          m_mi[pos] = c[3];
          if (m_cnt >= len - 1) begin
            e_wv = 1;
            e_mo = cfg_mosi_en ? m_mo : '0;
            e_mi = cfg_miso_en ? m_mi : '0;
            e_mo_ok = cfg_mosi_en;
            e_mi_ok = cfg_miso_en;
            m_cnt = 0; m_mo = '0; m_mi = '0;
          end else begin
            m_cnt++;
          end
        end
      end
      hist.push_back({spi_miso, spi_mosi, spi_cs, spi_sclk});
      while (hist.size() > 3) void'(hist.pop_front());
    end
  end

  // Per-cycle comparison and port observation
  int nwords = 0, nevts = 0;
  logic [127:0] last_mo = '0, last_mi = '0;
  logic last_mo_ok = 0, last_mi_ok = 0;
  logic last_known = 0, last_old = 0, last_new = 0;

  always @(negedge clk) begin
    if (!done_flag) begin
      check("R7 word_valid", 128'(word_valid), 128'(e_wv));
      check("R6 mosi_word", mosi_word, e_mo);
      check("R6 miso_word", miso_word, e_mi);
      check("R8 mosi_ok", 128'(mosi_ok), 128'(e_mo_ok));
      check("R8 miso_ok", 128'(miso_ok), 128'(e_mi_ok));
      check("R4 cs_evt_valid", 128'(cs_evt_valid), 128'(e_ev));
      if (e_ev) begin
        check("R4 cs_evt_old_known", 128'(cs_evt_old_known), 128'(e_known));
        check("R4 cs_evt_old", 128'(cs_evt_old), 128'(e_old));
        check("R4 cs_evt_new", 128'(cs_evt_new), 128'(e_new));
      end
      if (word_valid) begin
        nwords++; last_mo = mosi_word; last_mi = miso_word;
        last_mo_ok = mosi_ok; last_mi_ok = miso_ok;
      end
      if (cs_evt_valid) begin
        nevts++; last_known = cs_evt_old_known; last_old = cs_evt_old; last_new = cs_evt_new;
      end
    end
  end

  // Stimulus helpers
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [127:0] mo, input logic [127:0] mi, input int n);
    for (int b = 0; b < n; b++) begin
      int idx;
      idx = cfg_lsb_first ? b : (n - 1 - b);
      spi_mosi = mo[idx];
      spi_miso = mi[idx];
      tick(2);
      spi_sclk = ~spi_sclk;
      tick(4);
      spi_sclk = ~spi_sclk;
      tick(2);
    end
    tick(4);
  endtask

  task automatic cs_go(input bit asserted);
    spi_cs = cfg_cs_active_high ? asserted : !asserted;
    tick(4);
  endtask

  task automatic set_mode(input bit pol, input bit pha);
    cfg_cpol = pol; cfg_cpha = pha;
    tick(1);
    spi_sclk = pol;
    tick(6);
  endtask

  task automatic framed(input logic [127:0] mo, input logic [127:0] mi, input int n);
    cs_go(1);
    send(mo, mi, n);
    cs_go(0);
  endtask

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done_flag) begin
      done_flag = 1;
      miscompares++;
      $display("FAIL watchdog expired got %0d exp below 150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int w0;
    tick(1);
    // R1: reset state
    check("R1 word_valid in reset", 128'(word_valid), 128'(0));
    check("R1 mosi_word in reset", mosi_word, '0);
    check("R1 cs_evt_valid in reset", 128'(cs_evt_valid), 128'(0));
    tick(3);
    rst = 1'b0;
    tick(1);
    check("R1 outputs after release", {mosi_word[125:0], word_valid, cs_evt_valid}, '0);
    tick(7);
    // R5: startup event
    check("R5 startup event count", 128'(nevts), 128'(1));
    check("R5 startup old unknown", 128'(last_known), 128'(0));
    check("R5 startup level", 128'(last_new), 128'(1));

    // R2: all four modes
    for (int m = 0; m < 4; m++) begin
      logic [7:0] vo, vi;
      vo = 8'hA5 ^ 8'(m * 37);
      vi = 8'h3C + 8'(m * 11);
      set_mode(m[1], m[0]);
      w0 = nwords;
      framed(128'(vo), 128'(vi), 8);
      check($sformatf("R2 mode %0d word count", m), 128'(nwords - w0), 128'(1));
      check($sformatf("R2 mode %0d mosi", m), last_mo, 128'(vo));
      check($sformatf("R2 mode %0d miso", m), last_mi, 128'(vi));
    end
    set_mode(0, 0);

    // R6: bit order and position
    cfg_word_len = 8'd12;
    cfg_lsb_first = 1;
    framed(128'h0A3C, 128'h05E1, 12);
    check("R6 lsb-first mosi", last_mo, 128'h0A3C);
    check("R6 lsb-first miso", last_mi, 128'h05E1);
    cfg_lsb_first = 0;
    framed(128'h00F1, 128'h0803, 12);
    check("R6 msb-first mosi", last_mo, 128'h00F1);
    check("R6 msb-first miso", last_mi, 128'h0803);

    // R7: short words back to back, clamping, longest word
    cfg_word_len = 8'd4;
    w0 = nwords;
    cs_go(1);
    send(128'h9, 128'h6, 4);
    send(128'h3, 128'hC, 4);
    cs_go(0);
    check("R7 two 4-bit words", 128'(nwords - w0), 128'(2));
    check("R7 second 4-bit word", last_mo, 128'h3);
    cfg_word_len = 8'd3;
    w0 = nwords;
    framed(128'hB, 128'h4, 4);
    check("R7 length 3 clamps to 4 count", 128'(nwords - w0), 128'(1));
    check("R7 length 3 clamps to 4 value", last_mo, 128'hB);
    cfg_word_len = 8'd128;
    framed(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
           128'h8000_0000_0000_0000_0000_0000_0000_0001, 128);
    check("R7 128-bit mosi", last_mo, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    check("R7 128-bit miso", last_mi, 128'h8000_0000_0000_0000_0000_0000_0000_0001);
    cfg_word_len = 8'd8;

    // R4: partial word discarded by chip-select change
    w0 = nwords;
    framed(128'h15, 128'h0A, 5);
    framed(128'h66, 128'h99, 8);
    check("R4 partial word dropped", 128'(nwords - w0), 128'(1));
    check("R4 clean word after partial", last_mo, 128'h66);
    check("R4 last event known", 128'(last_known), 128'(1));
    check("R4 last event old", 128'(last_old), 128'(0));
    check("R4 last event new", 128'(last_new), 128'(1));

    // R4: chip select and sampling edge in the same cycle
    w0 = nwords;
    spi_mosi = 1'b1;
    spi_cs = 1'b0;
    spi_sclk = 1'b1;
    tick(4);
    spi_sclk = 1'b0;
    tick(4);
    send(128'h5A, 128'hA5, 8);
    cs_go(0);
    check("R4 coincident edge dropped count", 128'(nwords - w0), 128'(1));
    check("R4 coincident edge dropped value", last_mo, 128'h5A);

    // R3: edges ignored while deasserted, then active-high polarity
    w0 = nwords;
    send(128'hFF, 128'hFF, 8);
    check("R3 deasserted edges ignored", 128'(nwords - w0), 128'(0));
    framed(128'h81, 128'h18, 8);
    check("R3 no leftover bits", last_mo, 128'h81);
    spi_cs = 1'b0;
    tick(6);
    cfg_cs_active_high = 1;
    tick(2);
    w0 = nwords;
    send(128'hEE, 128'h11, 8);
    check("R3 active-high idle ignored", 128'(nwords - w0), 128'(0));
    framed(128'hC3, 128'h24, 8);
    check("R3 active-high word", last_mo, 128'hC3);
    check("R3 active-high count", 128'(nwords - w0), 128'(1));
    spi_cs = 1'b0;
    tick(4);
    cfg_cs_active_high = 0;
    tick(2);
    cs_go(0);

    // R8: channel disables
    cfg_miso_en = 0;
    framed(128'h77, 128'h55, 8);
    check("R8 miso disabled ok", 128'(last_mi_ok), 128'(0));
    check("R8 miso disabled word", last_mi, '0);
    check("R8 mosi enabled ok", 128'(last_mo_ok), 128'(1));
    cfg_miso_en = 1;
    cfg_mosi_en = 0;
    framed(128'h77, 128'h55, 8);
    check("R8 mosi disabled ok", 128'(last_mo_ok), 128'(0));
    check("R8 mosi disabled word", last_mo, '0);
    check("R8 miso enabled word", last_mi, 128'h55);
    cfg_mosi_en = 1;

    // R9: chip select unused
    cfg_cs_en = 0;
    tick(2);
    w0 = nwords;
    begin
      int e0;
      e0 = nevts;
      send(128'h12, 128'h34, 8);
      spi_cs = 1'b0;
      tick(4);
      send(128'h56, 128'h78, 8);
      spi_cs = 1'b1;
      tick(6);
      check("R9 no events without chip select", 128'(nevts - e0), 128'(0));
    end
    check("R9 words by count", 128'(nwords - w0), 128'(2));
    check("R9 last word", last_mo, 128'h56);
    cfg_cs_en = 1;
    tick(4);

    done_flag = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule